// File: doc/BRIEF.md
# Strided Queue Doorbell Decoder

This block watches writes into a controller's register space and picks out those that land in the doorbell area, which begins at byte offset 0x1000. Doorbell slots are laid out per queue in pairs: the first slot of a pair carries a new submission-queue tail and the second carries a new completion-queue head. A runtime stride input sets the spacing between slots to `4 << stride` bytes, so one queue pair spans `8 << stride` bytes.

For each write the block checks that the address is in the doorbell area and sits on a slot boundary. It also checks that the stride is legal, then works out the queue number and the doorbell kind. A write whose queue number is below the configured queue count produces a single-cycle doorbell pulse one clock later. That pulse carries the queue number, the kind and the low 16 bits of the write data. A well-placed write to a queue number that does not exist raises a one-cycle error flag instead. Everything else is dropped silently. Moving the queue pointers and arbitrating between queues are handled downstream.

Top module: `doorbell_decoder`

## Requirements
- R1: After reset is released, and before any write is accepted, `db_valid_o`, `db_err_o`, `db_is_cq_o`, `db_qid_o` and `db_ptr_o` are all zero.
- R2: A write whose offset `off = wr_addr_i - 0x1000` has bit (2+stride) equal to 0 is a submission-queue tail doorbell: `db_is_cq_o` = 0 and `db_qid_o` = `off >> (3+stride)`.
- R3: A write whose offset has bit (2+stride) equal to 1 is a completion-queue head doorbell: `db_is_cq_o` = 1 and `db_qid_o` = `(off - (1 << (2+stride))) >> (3+stride)`.
- R4: Every stride from 0 to 12 is honoured, giving a slot spacing of `4 << stride` bytes.
- R5: A write whose offset is not a multiple of `1 << (2+stride)` produces neither a pulse nor an error.
- R6: A write with `wr_addr_i` below 0x1000 produces neither a pulse nor an error.
- R7: A slot-aligned doorbell write whose decoded queue number is greater than or equal to `num_queues_i` produces no pulse and raises `db_err_o` for exactly one cycle.
- R8: `db_ptr_o` equals bits 15:0 of the write data. Bits above 15 have no effect.
- R9: An accepted write pulses `db_valid_o` high in the cycle after `wr_valid_i`, for one cycle per write. Back-to-back writes give back-to-back pulses.
- R10: While `stride_i` is greater than 12, no write produces a pulse or an error.
- R11: `db_is_cq_o`, `db_qid_o` and `db_ptr_o` keep the values of the last accepted doorbell until the next one. Dropped and erroring writes do not change them.
- R12: `db_valid_o` and `db_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (20) | Byte address of the write |
| wr_data_i | input | DATA_W (32) | Write data |
| stride_i | input | STRIDE_W (4) | Doorbell stride exponent, legal 0..12 |
| num_queues_i | input | QID_W+1 (9) | Number of existing queues |
| db_valid_o | output | 1 | One-cycle doorbell pulse |
| db_is_cq_o | output | 1 | 1 = completion head, 0 = submission tail |
| db_qid_o | output | QID_W (8) | Queue number of the doorbell |
| db_ptr_o | output | 16 | New head or tail value |
| db_err_o | output | 1 | One-cycle flag for a non-existent queue |

## Verification
The bench goes after the addresses where a stride-dependent shift is most likely to be off by one. These are slot 0 at exactly 0x1000, the completion slot of queue 0, the widest stride of 12, and offsets misaligned by a single low bit. A shifter that used the wrong stride would report the wrong queue or kind, or would let a misaligned write through. A design that compared against the queue count with `<=` instead of `<` would pulse for queue `num_queues_i` instead of flagging it. A missing stride bound would decode writes under stride 13. A design that loaded the payload on every write would corrupt the held values after dropped or erroring writes.

// File: rtl/db_dec_pkg.sv
package db_dec_pkg;
  localparam int unsigned DB_PTR_W = 16;
  localparam int unsigned DB_BASE  = 32'h1000;

  typedef struct packed {
    logic                is_cq;
    logic [DB_PTR_W-1:0] ptr;
  } db_payload_t;
endpackage

// File: rtl/db_slot_align.sv
// Locates the doorbell slot: range, alignment, kind and wide queue number.
module db_slot_align #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned MAX_STRIDE = 12,
  parameter int unsigned STRIDE_W   = 4
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [STRIDE_W-1:0] stride_i,
  output logic                hit_o,
  output logic                is_cq_o,
  output logic [ADDR_W-1:0]   qid_o
);
  import db_dec_pkg::*;

  localparam int unsigned NSTR = MAX_STRIDE + 1;
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(DB_BASE);

  logic [ADDR_W-1:0] off;
  logic              in_area;
  logic [NSTR-1:0]   aligned_v;
  logic [NSTR-1:0]   cq_v;
  logic [ADDR_W-1:0] qid_v [NSTR];

  assign in_area = (addr_i >= BASE);
  assign off     = addr_i - BASE;

  // One fixed-shift tap per legal stride; the stride input selects one.
  for (genvar g = 0; g < NSTR; g++) begin : g_tap
    assign aligned_v[g] = (off[g+1:0] == '0);
    assign cq_v[g]      = off[g+2];
    assign qid_v[g]     = off >> (g + 3);
  end

  always_comb begin
    hit_o   = 1'b0;
    is_cq_o = 1'b0;
    qid_o   = '0;
    for (int unsigned s = 0; s < NSTR; s++) begin
      if (stride_i == STRIDE_W'(s)) begin
        hit_o   = in_area && aligned_v[s];
        is_cq_o = cq_v[s];
        qid_o   = qid_v[s];
      end
    end
  end
endmodule

// File: rtl/db_qid_check.sv
// Range check of the decoded queue number against the configured count.
module db_qid_check #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned NQ_W   = 9
) (
  input  logic [ADDR_W-1:0] qid_i,
  input  logic [NQ_W-1:0]   num_q_i,
  output logic              ok_o
);
  localparam int unsigned CMP_W = (ADDR_W > NQ_W) ? ADDR_W : NQ_W;

  logic [CMP_W-1:0] qid_ext, nq_ext;
  assign qid_ext = CMP_W'(qid_i);
  assign nq_ext  = CMP_W'(num_q_i);
  assign ok_o    = (qid_ext < nq_ext);
endmodule

// File: rtl/doorbell_decoder.sv
module doorbell_decoder #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned QID_W      = 8,
  parameter int unsigned MAX_STRIDE = 12,
  parameter int unsigned STRIDE_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [QID_W:0]      num_queues_i,
  output logic                db_valid_o,
  output logic                db_is_cq_o,
  output logic [QID_W-1:0]    db_qid_o,
  output logic [15:0]         db_ptr_o,
  output logic                db_err_o
);
  import db_dec_pkg::*;

  localparam int unsigned NQ_W = QID_W + 1;

  logic              slot_hit, slot_cq, qid_ok;
  logic [ADDR_W-1:0] slot_qid;
  logic              accept, reject;
  db_payload_t       pay_d, pay_q;
  logic [QID_W-1:0]  qid_q;
  logic              valid_q, err_q;

  db_slot_align #(
    .ADDR_W    (ADDR_W),
    .MAX_STRIDE(MAX_STRIDE),
    .STRIDE_W  (STRIDE_W)
  ) u_align (
    .addr_i  (wr_addr_i),
    .stride_i(stride_i),
    .hit_o   (slot_hit),
    .is_cq_o (slot_cq),
    .qid_o   (slot_qid)
  );

  db_qid_check #(
    .ADDR_W(ADDR_W),
    .NQ_W  (NQ_W)
  ) u_qchk (
    .qid_i  (slot_qid),
    .num_q_i(num_queues_i),
    .ok_o   (qid_ok)
  );

  assign accept = wr_valid_i && slot_hit && qid_ok;
  assign reject = wr_valid_i && slot_hit && !qid_ok;

  assign pay_d.is_cq = slot_cq;
  assign pay_d.ptr   = wr_data_i[DB_PTR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= accept;
      err_q   <= reject;
    end
  end

  // Payload only moves on an accepted doorbell.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pay_q <= '0;
      qid_q <= '0;
    end else if (accept) begin
      pay_q <= pay_d;
      qid_q <= slot_qid[QID_W-1:0];
    end
  end

  assign db_valid_o = valid_q;
  assign db_err_o   = err_q;
  assign db_is_cq_o = pay_q.is_cq;
  assign db_qid_o   = qid_q;
  assign db_ptr_o   = pay_q.ptr;
endmodule

// File: rtl/doorbell_decoder_chk.sv
module doorbell_decoder_chk #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned QID_W      = 8,
  parameter int unsigned MAX_STRIDE = 12,
  parameter int unsigned STRIDE_W   = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_valid_i,
  input logic [ADDR_W-1:0]   wr_addr_i,
  input logic [DATA_W-1:0]   wr_data_i,
  input logic [STRIDE_W-1:0] stride_i,
  input logic [QID_W:0]      num_queues_i,
  input logic                db_valid_o,
  input logic                db_is_cq_o,
  input logic [QID_W-1:0]    db_qid_o,
  input logic [15:0]         db_ptr_o,
  input logic                db_err_o
);
  assert_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(db_valid_o && db_err_o));

  assert_pulse_needs_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_valid_o || db_err_o) |-> $past(wr_valid_i));

  assert_ptr_from_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_valid_o |-> (db_ptr_o == $past(wr_data_i[15:0])));

  assert_qid_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_valid_o |-> ({1'b0, db_qid_o} < $past(num_queues_i)));

  assert_no_pulse_low_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_addr_i < ADDR_W'(32'h1000)) |-> !(db_valid_o || db_err_o));

  assert_no_pulse_bad_stride_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stride_i > STRIDE_W'(MAX_STRIDE)) |-> !(db_valid_o || db_err_o));

  assert_hold_payload_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !db_valid_o |=> (!db_valid_o |-> ($stable(db_ptr_o) && $stable(db_qid_o)
                                      && $stable(db_is_cq_o))));
endmodule

bind doorbell_decoder doorbell_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .QID_W(QID_W),
  .MAX_STRIDE(MAX_STRIDE), .STRIDE_W(STRIDE_W)
) u_chk (.*);

// File: tb/doorbell_decoder_tb_top.sv
module doorbell_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 32;
  localparam int QID_W  = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_valid_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [3:0]        stride_i = '0;
  logic [QID_W:0]    num_queues_i = '0;
  logic              db_valid_o, db_is_cq_o, db_err_o;
  logic [QID_W-1:0]  db_qid_o;
  logic [15:0]       db_ptr_o;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic       e_valid, e_err, e_cq;
  logic [7:0] e_qid;
  logic [15:0] e_ptr;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  doorbell_decoder dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .stride_i(stride_i),
    .num_queues_i(num_queues_i), .db_valid_o(db_valid_o),
    .db_is_cq_o(db_is_cq_o), .db_qid_o(db_qid_o), .db_ptr_o(db_ptr_o),
    .db_err_o(db_err_o)
  );

  // Reference model from the requirements; updates held payload on accept.
  task automatic model(input logic v, input longint a, input longint d,
                       input int s, input int nq);
    longint off, q;
    int sh;
    bit cq;
    e_valid = 0;
    e_err   = 0;
    if (!v || a < 64'h1000 || s > 12) return;
    sh  = 2 + s;
    off = a - 64'h1000;
    if ((off & ((64'd1 << sh) - 1)) != 0) return;
    cq = off[sh];
    q  = cq ? (off - (64'd1 << sh)) >> (sh + 1) : off >> (sh + 1);
    if (q < nq) begin
      e_valid = 1;
      e_cq    = cq;
      e_qid   = q[7:0];
      e_ptr   = d[15:0];
    end else begin
      e_err = 1;
    end
  endtask

  task automatic compare(input string tag);
    n_checks++;
    if (db_valid_o !== e_valid || db_err_o !== e_err || db_is_cq_o !== e_cq ||
        db_qid_o !== e_qid || db_ptr_o !== e_ptr) begin
      n_errors++;
      $display("FAIL %s: actual v=%0b e=%0b cq=%0b q=%0d p=%h expected v=%0b e=%0b cq=%0b q=%0d p=%h",
               tag, db_valid_o, db_err_o, db_is_cq_o, db_qid_o, db_ptr_o,
               e_valid, e_err, e_cq, e_qid, e_ptr);
    end
  endtask

  // Called at a negedge: apply, let one posedge register it, check at next negedge.
  task automatic step(input logic v, input longint a, input longint d,
                      input int s, input int nq, input string tag);
    wr_valid_i   = v;
    wr_addr_i    = a[ADDR_W-1:0];
    wr_data_i    = d[DATA_W-1:0];
    stride_i     = s[3:0];
    num_queues_i = nq[QID_W:0];
    model(v, {44'd0, a[ADDR_W-1:0]}, d, s, nq);
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
  endtask

  function automatic longint slot(input int q, input int cq, input int s);
    return 64'h1000 + longint'(q) * (64'd8 << s) + longint'(cq) * (64'd4 << s);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    e_valid = 0; e_err = 0; e_cq = 0; e_qid = 0; e_ptr = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 reset");

    // Directed corners
    step(1, 64'h1000, 64'hDEAD_1234, 0, 4, "R2 sq q0 stride0");
    step(1, 64'h1004, 64'h0000_5678, 0, 4, "R3 cq q0 stride0");
    step(1, slot(3, 0, 0), 64'hFFFF_0042, 0, 4, "R2 sq q3 last valid");
    step(1, slot(4, 1, 0), 64'h0000_9999, 0, 4, "R7 qid equal count");
    step(0, 0, 0, 0, 4, "R7 err one cycle");
    step(1, 64'h1002, 64'h1111, 0, 4, "R5 misaligned by 2");
    step(1, 64'h1001, 64'h1111, 0, 4, "R5 misaligned by 1");
    step(1, 64'h0FFC, 64'h2222, 0, 4, "R6 below base");
    step(1, slot(1, 1, 12), 64'hABCD_7777, 12, 4, "R4 cq q1 stride12");
    step(1, slot(1, 0, 12) + 64'h800, 64'h3333, 12, 4, "R5 misaligned stride12");
    step(1, 64'h1000, 64'h4444, 13, 4, "R10 stride13");
    step(1, slot(2, 1, 3), 64'h0001_0005, 3, 4, "R9 back to back a");
    step(1, slot(2, 0, 3), 64'h0002_0006, 3, 4, "R9 back to back b");
    step(0, slot(2, 0, 3), 64'h0003_0007, 3, 4, "R9 idle drops pulse");
    step(1, slot(0, 0, 5), 64'hFFFF_FFFF, 5, 1, "R8 upper data bits");
    step(1, slot(0, 1, 0), 64'h1, 0, 0, "R11 err keeps payload");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int s, nq, q, cq, mode;
      longint a, d;
      s    = ($urandom % 16 == 0) ? 13 + ($urandom % 3) : $urandom % 13;
      nq   = 1 + ($urandom % 64);
      q    = $urandom % (nq + 3);
      cq   = $urandom % 2;
      mode = $urandom % 8;
      a    = slot(q, cq, s);
      if (mode == 0) a = a + (64'd1 << ($urandom % (2 + s)));
      else if (mode == 1) a = $urandom % 32'h1000;
      if (a >= (64'd1 << ADDR_W)) a = $urandom % (32'd1 << ADDR_W);
      d = {32'd0, $urandom};
      step(($urandom % 5) != 0, a, d, s, nq,
           (mode == 0) ? "R5 rnd" : (mode == 1) ? "R6 rnd" :
           (s > 12) ? "R10 rnd" : (q >= nq) ? "R7 rnd" :
           cq ? "R3 rnd" : "R2 rnd");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule